// File: doc/BRIEF.md
# Configurable Burst Read Sequencer

This block drives the synchronous read side of a word-wide memory. A single configuration write loads a burst setup register from bits of the write's address bus. Each later read access starts when the address-valid strobe is seen high with a start address. From then on the block counts the initial wait cycles, generates the sequence of word addresses for an internal array, and raises a data-valid flag and a ready flag. The ready flag is timed as configured.

Five settings are chosen at run time: read mode, ready timing, active clock edge, burst ordering and initial latency. A burst runs until the next access, a switch to asynchronous mode, or a reset. Inputs are always sampled on the rising clock edge. When the falling edge is selected, the outputs are re-registered on the falling edge, so every output change lands on that edge.

Top module: `burst_seq`

## Requirements
- R1: After reset the setup is: asynchronous mode, ready with data, rising edge, continuous ordering, latency code 5. In this state the outputs `data_valid` and `ready` stay 0 even when accesses are issued.
- R2: A configuration write with `cfg_addr[19]`=0 enables synchronous bursts. Every access after that produces a data burst.
- R3: `cfg_addr[14:12]` holds a latency code c from 0 to 5. The access is sampled at rising edge k. `data_valid` first goes high after edge k+c+2, and `mem_addr` then equals the start address.
- R4: A configuration write with latency code 6 or 7 leaves the latency unchanged. All other fields of that write still take effect.
- R5: With `cfg_addr[18]`=1, `ready` equals `data_valid` on every cycle.
- R6: With `cfg_addr[18]`=0, `ready` goes high one cycle before `data_valid` first goes high. It stays high for the rest of the burst.
- R7: `cfg_addr[16:15]`=00 selects continuous ordering. The whole address increments by one on each data cycle and wraps past the all-ones value.
- R8: `cfg_addr[16:15]` = 01, 10 or 11 selects a wrap of 8, 16 or 32 words. The low 3, 4 or 5 address bits count modulo the wrap length, and the upper bits stay fixed.
- R9: With `cfg_addr[17]`=0, all outputs change on the falling clock edge and carry the same sequence half a cycle later. With `cfg_addr[17]`=1, all outputs change on the rising edge.
- R10: An access issued during a burst restarts it: `data_valid` drops, and the latency count begins again from the new address.
- R11: Writing `cfg_addr[19]`=1 stops any burst within one cycle. While that mode holds, `data_valid` and `ready` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| avd | input | 1 | Access strobe; high for one cycle with the start address |
| start_addr | input | ADDR_W | Word address of the first data word |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_addr | input | ADDR_W | Address bus of the configuration write; bits 19..12 hold the fields |
| mem_addr | output | ADDR_W | Word address presented to the internal array |
| data_valid | output | 1 | High while `mem_addr` points at a valid burst word |
| ready | output | 1 | Ready flag, timed with or one cycle ahead of data |

## Verification
The assertions assume three things about the inputs. A configuration write never shares a cycle with an access strobe. The ordering checks apply only in cycles with no strobe and no configuration write. Latency is changed only when the data phase will restart or has already settled. The stimulus issues every configuration write on an idle strobe cycle. It starts each burst with a single-cycle strobe and lets bursts run long enough to wrap several times, and when it restarts or stops a burst it does so with the other input held low. The bench model has its own address arithmetic (division and remainder). It checks the outputs twice per cycle, before and after the falling edge, so edge placement is checked as well as values.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BIT_ASYNC  = 19;
    localparam int BIT_RDYWD  = 18;
    localparam int BIT_RISE   = 17;
    localparam int BIT_ORD_LO = 15;
    localparam int BIT_LAT_LO = 12;
    localparam int CFG_LO     = BIT_LAT_LO;
    localparam int CFG_W      = BIT_ASYNC - BIT_LAT_LO + 1;
    localparam int CNT_W      = 4;
    localparam logic [2:0] LAT_CODE_MAX = 3'd5;

    typedef enum logic [1:0] {
        ORD_CONT   = 2'b00,
        ORD_WRAP8  = 2'b01,
        ORD_WRAP16 = 2'b10,
        ORD_WRAP32 = 2'b11
    } order_e;

    typedef struct packed {
        logic       sync_en;
        logic       rdy_with_data;
        logic       rise_edge;
        order_e     order;
        logic [2:0] lat_code;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{
        sync_en:       1'b0,
        rdy_with_data: 1'b1,
        rise_edge:     1'b1,
        order:         ORD_CONT,
        lat_code:      3'd5
    };

    // number of rising edges from access strobe to first data word
    function automatic logic [CNT_W-1:0] lat_edges(input logic [2:0] code);
        return CNT_W'(code) + CNT_W'(2);
    endfunction

    // low-bit mask that counts within a wrapped burst
    function automatic logic [5:0] wrap_mask(input order_e ord);
        case (ord)
            ORD_WRAP8:  return 6'd7;
            ORD_WRAP16: return 6'd15;
            ORD_WRAP32: return 6'd31;
            default:    return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] fields,
    output cfg_t             cfg
);
    localparam int OFF_ASYNC = BIT_ASYNC  - CFG_LO;
    localparam int OFF_RDYWD = BIT_RDYWD  - CFG_LO;
    localparam int OFF_RISE  = BIT_RISE   - CFG_LO;
    localparam int OFF_ORD   = BIT_ORD_LO - CFG_LO;
    localparam int OFF_LAT   = BIT_LAT_LO - CFG_LO;

    logic [2:0] new_lat;
    assign new_lat = fields[OFF_LAT +: 3];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_DEFAULT;
        end else if (we) begin
            cfg.sync_en       <= ~fields[OFF_ASYNC];
            cfg.rdy_with_data <= fields[OFF_RDYWD];
            cfg.rise_edge     <= fields[OFF_RISE];
            cfg.order         <= order_e'(fields[OFF_ORD +: 2]);
            if (new_lat <= LAT_CODE_MAX)
                cfg.lat_code <= new_lat;
        end
    end
endmodule

// File: rtl/burst_engine.sv
module burst_engine
    import burst_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              avd,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              dv,
    output logic              rdy,
    output logic [ADDR_W-1:0] addr
);
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] mask;
    logic [CNT_W-1:0]  lat;
    logic              in_data;

    assign lat      = lat_edges(cfg.lat_code);
    assign in_data  = active && (cnt >= lat);
    assign mask     = {{(ADDR_W-6){1'b0}}, wrap_mask(cfg.order)};
    assign addr_inc = addr_q + ADDR_W'(1);
    assign addr_nxt = (cfg.order == ORD_CONT) ? addr_inc
                    : ((addr_q & ~mask) | (addr_inc & mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            addr_q <= '0;
        end else if (!cfg.sync_en) begin
            active <= 1'b0;
        end else if (avd) begin
            active <= 1'b1;
            cnt    <= '0;
            addr_q <= start_addr;
        end else if (active) begin
            if (in_data)
                addr_q <= addr_nxt;
            else
                cnt <= cnt + CNT_W'(1);
        end
    end

    assign dv   = in_data;
    assign rdy  = cfg.rdy_with_data ? in_data
                                    : (active && (cnt >= (lat - CNT_W'(1))));
    assign addr = addr_q;
endmodule

// File: rtl/burst_edge_out.sv
module burst_edge_out #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise_sel,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] fall_q;

    always_ff @(negedge clk) begin
        if (rst)
            fall_q <= '0;
        else
            fall_q <= d;
    end

    assign q = rise_sel ? d : fall_q;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              avd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              data_valid,
    output logic              ready
);
    localparam int OUT_W = ADDR_W + 2;

    cfg_t              cfg_q;
    logic              eng_dv;
    logic              eng_rdy;
    logic [ADDR_W-1:0] eng_addr;
    logic [OUT_W-1:0]  out_bus;
    logic              unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_addr[ADDR_W-1:BIT_ASYNC+1], cfg_addr[CFG_LO-1:0]};

    burst_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .fields (cfg_addr[BIT_ASYNC:CFG_LO]),
        .cfg    (cfg_q)
    );

    burst_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .avd        (avd),
        .start_addr (start_addr),
        .dv         (eng_dv),
        .rdy        (eng_rdy),
        .addr       (eng_addr)
    );

    burst_edge_out #(.W(OUT_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .rise_sel (cfg_q.rise_edge),
        .d        ({eng_dv, eng_rdy, eng_addr}),
        .q        (out_bus)
    );

    assign data_valid = out_bus[OUT_W-1];
    assign ready      = out_bus[OUT_W-2];
    assign mem_addr   = out_bus[ADDR_W-1:0];
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              avd,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input cfg_t              cfg,
    input logic              eng_dv,
    input logic              eng_rdy,
    input logic [ADDR_W-1:0] eng_addr
);
    logic [ADDR_W-1:0] low_mask;
    assign low_mask = {{(ADDR_W-6){1'b0}}, wrap_mask(cfg.order)};

    // R4: reserved latency codes do not alter the latency field
    a_r4_reserved_lat_kept: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_addr[BIT_LAT_LO +: 3] > LAT_CODE_MAX)) |=> $stable(cfg.lat_code));

    // R6: early ready is followed by data on the next cycle
    a_r6_ready_leads_data: assert property (@(posedge clk) disable iff (rst)
        ($rose(eng_rdy) && !cfg.rdy_with_data && cfg.sync_en && !avd && !cfg_we) |=> eng_dv);

    // R7: continuous ordering steps the whole address by one
    a_r7_cont_step: assert property (@(posedge clk) disable iff (rst)
        (eng_dv && cfg.sync_en && cfg.order == ORD_CONT && !avd && !cfg_we)
        |=> (eng_addr == $past(eng_addr) + ADDR_W'(1)));

    // R8: wrapped ordering keeps upper bits and moves the low bits
    a_r8_wrap_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (eng_dv && cfg.sync_en && cfg.order != ORD_CONT && !avd && !cfg_we)
        |=> (((eng_addr & ~low_mask) == ($past(eng_addr) & ~low_mask))
             && (eng_addr != $past(eng_addr))));

    // R10: a new access removes data for at least one cycle
    a_r10_restart_drops_data: assert property (@(posedge clk) disable iff (rst)
        (avd && cfg.sync_en) |=> !eng_dv);

    // R11: asynchronous mode holds both flags low
    a_r11_async_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg.sync_en && $past(!cfg.sync_en)) |-> (!eng_dv && !eng_rdy));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .avd      (avd),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg      (cfg_q),
    .eng_dv   (eng_dv),
    .eng_rdy  (eng_rdy),
    .eng_addr (eng_addr)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          avd = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          data_valid;
    logic          ready;

    always #10 clk = ~clk;

    burst_seq #(.ADDR_W(AW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .avd        (avd),
        .start_addr (start_addr),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .mem_addr   (mem_addr),
        .data_valid (data_valid),
        .ready      (ready)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag      = "R1";

    // reference state
    bit            m_sync, m_rdywd, m_rise;
    int            m_order, m_lat;
    bit            m_active;
    int            m_cnt;
    logic [AW-1:0] m_addr;
    bit            e_dv, e_rdy, p_dv, p_rdy;
    logic [AW-1:0] e_addr, p_addr;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input int ord);
        longint unsigned n, base, off;
        if (ord == 0) return a + 1'b1;
        n    = 64'd8 << (ord - 1);
        off  = longint'(a) % n;
        base = longint'(a) - off;
        return AW'(base + ((off + 1) % n));
    endfunction

    function automatic logic [AW-1:0] mkcfg(input bit async_m, input bit rdywd,
                                           input bit rise, input int ord, input int lat);
        logic [AW-1:0] v;
        v        = AW'(22'h2A5A5);
        v[19]    = async_m;
        v[18]    = rdywd;
        v[17]    = rise;
        v[16:15] = ord[1:0];
        v[14:12] = lat[2:0];
        return v;
    endfunction

    task automatic model_step();
        int need;
        if (rst) begin
            m_sync = 0; m_rdywd = 1; m_rise = 1; m_order = 0; m_lat = 5;
            m_active = 0; m_cnt = 0; m_addr = '0;
        end else begin
            need = m_lat + 2;
            if (!m_sync) m_active = 0;
            else if (avd) begin
                m_active = 1; m_cnt = 0; m_addr = start_addr;
            end else if (m_active) begin
                if (m_cnt >= need) m_addr = advance(m_addr, m_order);
                else m_cnt++;
            end
            if (cfg_we) begin
                m_sync  = !cfg_addr[19];
                m_rdywd = cfg_addr[18];
                m_rise  = cfg_addr[17];
                m_order = int'(cfg_addr[16:15]);
                if (cfg_addr[14:12] < 3'd6) m_lat = int'(cfg_addr[14:12]);
            end
        end
        p_dv = e_dv; p_rdy = e_rdy; p_addr = e_addr;
        e_dv   = m_active && (m_cnt >= m_lat + 2);
        e_rdy  = m_rdywd ? e_dv : (m_active && (m_cnt >= m_lat + 1));
        e_addr = m_addr;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
        end
    endtask

    task automatic compare(input bit dv, input bit rd, input logic [AW-1:0] ad, input string req);
        chk(req, "data_valid", longint'(data_valid), longint'(dv));
        chk(req, "ready", longint'(ready), longint'(rd));
        if (dv) chk(req, "mem_addr", longint'(mem_addr), longint'(ad));
    endtask

    task automatic step(input bit r, input bit a, input logic [AW-1:0] sa,
                        input bit w, input logic [AW-1:0] ca);
        rst = r; avd = a; start_addr = sa; cfg_we = w; cfg_addr = ca;
        @(posedge clk);
        model_step();
        #8;
        if (!r) begin
            if (m_rise) compare(e_dv, e_rdy, e_addr, tag);
            else        compare(p_dv, p_rdy, p_addr, "R9");
        end
        #7;
        if (!r) compare(e_dv, e_rdy, e_addr, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0);
    endtask

    task automatic access(input logic [AW-1:0] a);
        step(0, 1, a, 0, '0);
    endtask

    task automatic setcfg(input bit async_m, input bit rdywd, input bit rise,
                          input int ord, input int lat);
        step(0, 0, '0, 1, mkcfg(async_m, rdywd, rise, ord, lat));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        e_dv = 0; e_rdy = 0; e_addr = '0;
        for (int i = 0; i < 3; i++) step(1, 0, '0, 0, '0);

        // R1: defaults after reset, accesses ignored in asynchronous mode
        tag = "R1";
        idle(2);
        access(22'h00123);
        idle(10);

        // R2: synchronous mode enabled, continuous ordering across a carry
        tag = "R2";
        setcfg(0, 1, 1, 0, 0);
        access(22'h000FC);
        idle(12);

        // R3: every latency code from 0 to 5
        tag = "R3";
        for (int c = 0; c < 6; c++) begin
            setcfg(0, 1, 1, 0, c);
            access(AW'(22'h01000 + c * 16));
            idle(c + 6);
        end

        // R7: continuous wrap past the all-ones address
        tag = "R7";
        setcfg(0, 1, 1, 0, 2);
        access(22'h3FFFFB);
        idle(12);

        // R6: ready one cycle ahead, 8-word wrap
        tag = "R6";
        setcfg(0, 0, 1, 1, 3);
        access(22'h12345);
        idle(20);

        // R8: 16- and 32-word wraps
        tag = "R8";
        setcfg(0, 1, 1, 2, 5);
        access(22'h2ABCD);
        idle(30);
        setcfg(0, 0, 1, 3, 1);
        access(22'h3FFFE);
        idle(40);

        // R5: ready with data
        tag = "R5";
        setcfg(0, 1, 1, 0, 4);
        access(22'h00500);
        idle(10);

        // R4: reserved latency codes keep latency 4, other fields change
        tag = "R4";
        setcfg(0, 0, 1, 1, 7);
        access(22'h00777);
        idle(14);
        setcfg(0, 1, 1, 2, 6);
        access(22'h00888);
        idle(24);

        // R9: falling-edge output timing
        tag = "R9";
        setcfg(0, 1, 0, 2, 1);
        access(22'h0ABC3);
        idle(25);
        setcfg(0, 0, 0, 0, 0);
        access(22'h3FFFD);
        idle(10);

        // R10: restart during a burst
        tag = "R10";
        setcfg(0, 1, 1, 0, 2);
        access(22'h00100);
        idle(8);
        access(22'h02200);
        idle(8);

        // R11: switch to asynchronous mode during a burst
        tag = "R11";
        setcfg(1, 1, 1, 0, 2);
        idle(6);
        access(22'h00300);
        idle(8);

        // R1: reset restores defaults after a changed setup
        tag = "R1";
        setcfg(0, 0, 0, 3, 0);
        access(22'h00400);
        idle(4);
        step(1, 0, '0, 0, '0);
        idle(2);
        access(22'h00400);
        idle(8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule